// File: doc/BRIEF.md
# Audio Serial Dual FIFO Register Interface

This block sits between a processor bus and an audio serial port. It holds two FIFOs, each 16 bits wide and 32 entries deep: one carries samples from the bus to the serial transmitter and the other carries samples from the serial receiver to the bus. Each entry holds one halfword, whatever the audio sample size.

The bus sees two locations, chosen by `bus_sel`. The control location (`bus_sel`=0) holds a mode bit and an enable bit for each direction, and it reports the live fill count of both FIFOs. The data entry location (`bus_sel`=1) is shared by both directions: a write pushes into the transmit FIFO and a read pops from the receive FIFO. On the serial side, the transmit FIFO is drained and the receive FIFO is filled through valid/ready handshakes. In DMA mode, a request output per direction tells an external DMA engine when it may move data.

A bus read returns its data in `bus_rdata` on the cycle after the read is presented, and `bus_rdata` holds that value until the next read.

Top module: `snd_dual_fifo`

## Requirements
- R1: After reset, the control word reads 0x0000. `tx_valid`, `rx_ready`, `tx_dreq`, `rx_dreq`, `tx_ovf` and `rx_unf` are all low.
- R2: In the control word, bit 15 selects transmit DMA mode, bit 14 selects receive DMA mode, bit 13 enables transmit and bit 12 enables receive (1 = DMA or enabled). These four bits read back as written. Writes to bits 11:0 are ignored.
- R3: Halfwords written to the entry location while transmit is enabled appear on `tx_data` in write order. `tx_valid` is high exactly while the transmit FIFO is enabled and non-empty. A pop occurs on a cycle with `tx_valid` and `tx_ready` both high.
- R4: Bits 11:6 of the control word give the transmit fill count (0 to 32). A control read reflects every push and pop that completed on an earlier clock edge.
- R5: An entry write while the transmit count is 32 is dropped and sets the sticky `tx_ovf` flag. The count stays 32.
- R6: `rx_ready` is high exactly while receive is enabled and its count is below 32. A push occurs on a cycle with `rx_valid` and `rx_ready` both high. Entry reads return the received halfwords in arrival order. Bits 5:0 of the control word give the receive count (0 to 32).
- R7: An entry read while receive is enabled and empty returns 0 and sets the sticky `rx_unf` flag.
- R8: While a direction's enable bit is 0, that FIFO is flushed on the next clock edge and its count stays 0. Its sticky flag is cleared. Bus and serial pushes and pops to it are ignored: `tx_valid` or `rx_ready` is low, and an entry read returns 0.
- R9: `tx_dreq` is high exactly when transmit DMA mode is set, transmit is enabled and the transmit count is below 32.
- R10: `rx_dreq` is high exactly when receive DMA mode is set, receive is enabled and the receive count is above 0.
- R11: A push and a pop to the same FIFO in the same cycle both complete, and that FIFO's count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 = control word, 1 = data entry |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, valid the cycle after `bus_rd` |
| tx_data | output | 16 | Oldest transmit halfword |
| tx_valid | output | 1 | Transmit data available |
| tx_ready | input | 1 | Serial side takes `tx_data` |
| rx_data | input | 16 | Received halfword |
| rx_valid | input | 1 | Received halfword present |
| rx_ready | output | 1 | Receive FIFO can accept |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
The assertions check on every cycle that both counts stay within 32, that a disabled FIFO is empty and flag-free one cycle later, that a simultaneous push and pop leaves the count alone, and that the sticky flags rise only on a full or empty access and then persist. Only the bench scenarios can show data order through all 32 entries, the dropped write at full and the zero returned from an empty read. They also cover the control word readback with its ignored count bits, and the DMA request levels in each mode and fill state.

// File: rtl/snd_dual_fifo.sv
module snd_dual_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          tx_ovf,
  output logic          rx_unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic tx_dma, rx_dma, tx_en, rx_en;
  logic [DW-1:0] tmem [DEPTH];
  logic [DW-1:0] rmem [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  wire ctl_wr = bus_wr && !bus_sel;
  wire ctl_rd = bus_rd && !bus_sel;
  wire ent_wr = bus_wr && bus_sel;
  wire ent_rd = bus_rd && bus_sel;

  wire tfull  = tcnt == FULL;
  wire rempty = rcnt == '0;
  wire tpush  = ent_wr && tx_en && !tfull;
  wire tpop   = tx_valid && tx_ready;
  wire rpush  = rx_valid && rx_ready;
  wire rpop   = ent_rd && rx_en && !rempty;

  wire [15:0] ctl_word = {tx_dma, rx_dma, tx_en, rx_en, 6'(tcnt), 6'(rcnt)};

  assign tx_valid = tx_en && tcnt != '0;
  assign tx_data  = tmem[trp];
  assign rx_ready = rx_en && rcnt != FULL;
  assign tx_dreq  = tx_dma && tx_en && !tfull;
  assign rx_dreq  = rx_dma && rx_en && !rempty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {tx_dma, rx_dma, tx_en, rx_en} <= '0;
      bus_rdata <= '0;
    end else begin
      if (ctl_wr) {tx_dma, rx_dma, tx_en, rx_en} <= bus_wdata[15:12];
      if (ctl_rd) bus_rdata <= ctl_word;
      else if (ent_rd) bus_rdata <= rpop ? 16'(rmem[rrp]) : 16'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (tpush) tmem[twp] <= DW'(bus_wdata);
    if (rpush) rmem[rwp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      twp <= '0; trp <= '0; tcnt <= '0; tx_ovf <= 1'b0;
    end else begin
      if (tpush) twp <= bump(twp);
      if (tpop)  trp <= bump(trp);
      tcnt <= tcnt + CW'(tpush) - CW'(tpop);
      if (ent_wr && tfull) tx_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      rwp <= '0; rrp <= '0; rcnt <= '0; rx_unf <= 1'b0;
    end else begin
      if (rpush) rwp <= bump(rwp);
      if (rpop)  rrp <= bump(rrp);
      rcnt <= rcnt + CW'(rpush) - CW'(rpop);
      if (ent_rd && rempty) rx_unf <= 1'b1;
    end
  end

  // R4
  tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= FULL);
  // R6
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= FULL);
  // R8
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tcnt == '0) && !tx_ovf);
  // R8
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rcnt == '0) && !rx_unf);
  // R11
  tx_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && tpush && tpop |=> $stable(tcnt));
  // R11
  rx_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rpush && rpop |=> $stable(rcnt));
  // R5
  tx_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ovf) |-> $past(tcnt) == FULL);
  // R5
  tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && tx_en |=> tx_ovf);
  // R7
  rx_unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_unf) |-> $past(rcnt) == '0);
  // R9
  tx_dreq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> tx_ready || tcnt != FULL);
endmodule

// File: tb/snd_dual_fifo_tb.sv
module snd_dual_fifo_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, tx_data, rx_data = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic tx_dreq, rx_dreq, tx_ovf, rx_unf;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] rd;

  always #4 clk = ~clk;

  snd_dual_fifo u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rdx(input logic sel, output logic [15:0] d);
    @(negedge clk); bus_sel = sel; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdx(0, rd);
    chk(rd == 0, "R1 ctrl", rd, 0);
    chk({tx_valid, rx_ready, tx_dreq, rx_dreq, tx_ovf, rx_unf} == 0, "R1 outputs",
        {tx_valid, rx_ready, tx_dreq, rx_dreq, tx_ovf, rx_unf}, 0);

    wr(0, 16'hFFFF); rdx(0, rd);
    chk(rd == 16'hF000, "R2 count bits ignored", rd, 16'hF000);
    wr(0, 16'h3000); rdx(0, rd);
    chk(rd == 16'h3000, "R2 readback", rd, 16'h3000);
    chk(tx_dreq == 0, "R9 normal mode", tx_dreq, 0);
    wr(0, 16'hB000);
    chk(tx_dreq == 1, "R9 dma empty", tx_dreq, 1);

    for (int i = 0; i < 32; i++) begin
      wr(1, 16'(i * 3 + 1)); rdx(0, rd);
      chk(rd[11:6] == 6'(i + 1), "R4 tx count", rd[11:6], i + 1);
      chk(tx_dreq == (i < 31), "R9 dreq level", tx_dreq, i < 31);
    end
    wr(1, 16'hBEEF); rdx(0, rd);
    chk(rd[11:6] == 32 && tx_ovf, "R5 overflow", {rd[11:6], tx_ovf}, {6'd32, 1'b1});
    @(negedge clk); tx_ready = 1;
    for (int i = 0; i < 32; i++) begin
      chk(tx_valid && tx_data == 16'(i * 3 + 1), "R3 order", tx_data, i * 3 + 1);
      @(negedge clk);
    end
    tx_ready = 0;
    chk(!tx_valid, "R3 empty valid", tx_valid, 0);
    chk(tx_ovf, "R5 sticky", tx_ovf, 1);
    rdx(0, rd);
    chk(rd[11:6] == 0, "R4 drained", rd[11:6], 0);

    for (int i = 0; i < 5; i++) wr(1, 16'(100 + i));
    @(negedge clk);
    chk(tx_data == 100, "R11 head", tx_data, 100);
    tx_ready = 1; bus_sel = 1; bus_wdata = 105; bus_wr = 1;
    @(negedge clk); tx_ready = 0; bus_wr = 0;
    rdx(0, rd);
    chk(rd[11:6] == 5, "R11 count held", rd[11:6], 5);
    tx_ready = 1;
    for (int i = 1; i <= 5; i++) begin
      chk(tx_data == 16'(100 + i), "R11 order", tx_data, 100 + i);
      @(negedge clk);
    end
    tx_ready = 0;

    wr(1, 7); wr(1, 8);
    wr(0, 16'h1000); @(negedge clk);
    rdx(0, rd);
    chk(rd == 16'h1000 && !tx_ovf && !tx_valid, "R8 tx flush", rd, 16'h1000);
    wr(1, 9); rdx(0, rd);
    chk(rd[11:6] == 0, "R8 tx push ignored", rd[11:6], 0);
    chk(!tx_dreq, "R9 disabled", tx_dreq, 0);

    wr(0, 16'h7000);
    chk(!rx_dreq && rx_ready, "R10 empty", {rx_dreq, rx_ready}, 1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk(rx_ready, "R6 ready", rx_ready, 1);
      rx_data = 16'(i) ^ 16'h5A5A; rx_valid = 1;
    end
    @(negedge clk);
    chk(!rx_ready && rx_dreq, "R6 full", {rx_ready, rx_dreq}, 1);
    rx_data = 16'hDEAD;
    @(negedge clk); rx_valid = 0;
    rdx(0, rd);
    chk(rd[5:0] == 32, "R6 count full", rd[5:0], 32);
    for (int i = 0; i < 32; i++) begin
      rdx(1, rd);
      chk(rd == (16'(i) ^ 16'h5A5A), "R6 order", rd, 16'(i) ^ 16'h5A5A);
      chk(rx_dreq == (i < 31), "R10 dreq level", rx_dreq, i < 31);
    end
    rdx(1, rd);
    chk(rd == 0 && rx_unf, "R7 underflow", {rd, 15'(0), rx_unf}, 1);
    rdx(0, rd);
    chk(rd[5:0] == 0, "R6 count empty", rd[5:0], 0);

    @(negedge clk); rx_data = 16'h1234; rx_valid = 1; bus_sel = 1; bus_rd = 1;
    @(negedge clk); rx_valid = 0; bus_rd = 0;
    chk(bus_rdata == 0, "R7 empty same cycle", bus_rdata, 0);
    @(negedge clk); rx_data = 16'h2345; rx_valid = 1; bus_rd = 1;
    @(negedge clk); rx_valid = 0; bus_rd = 0;
    chk(bus_rdata == 16'h1234, "R11 rx pop", bus_rdata, 16'h1234);
    rdx(0, rd);
    chk(rd[5:0] == 1, "R11 rx count held", rd[5:0], 1);

    wr(0, 16'h2000); @(negedge clk);
    chk(!rx_ready && !rx_unf && !rx_dreq, "R8 rx flush", {rx_ready, rx_unf, rx_dreq}, 0);
    rdx(1, rd);
    chk(rd == 0 && !rx_unf, "R8 rx read ignored", rd, 0);
    wr(0, 16'h3000); rdx(0, rd);
    chk(rd[5:0] == 0, "R8 rx count zero", rd[5:0], 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule